// File: doc/BRIEF.md
# Gated Sequential Channel Selector

This block walks a single active channel through a short, repeating sequence. A square-wave carrier is inverted to form a count clock, and each rising edge of that clock moves a 4-bit up counter forward by one. A 4-to-16 decoder turns the count into sixteen active-low select lines, and exactly one of them is low at a time while the decoder is enabled.

The sequence length is fixed by a terminal channel parameter. When the decoder selects the terminal channel, the counter is cleared on the next system clock. As a result, only the channels below the terminal are held for a full count period. With a terminal value of 16 the feedback is removed, and the counter wraps from 15 to 0.

Each channel in use drives three things: two switch-enable outputs, an active-high indicator, and a gated drive. The gated drive is the AND of the carrier, a burst-gate window and the channel select. All inputs are sampled on a single system clock.

Top module: `seqsel_top`

## Requirements
- R1: After synchronous reset the count is 0, so while the decoder is enabled `sel_n_o` reads 16'hFFFE and `ind_o` has only bit 0 set.
- R2: A high-to-low transition of `carrier_i` is a rising edge of the count clock. When `cnt_down_i` is high, the count rises by one on the second system clock edge after the low level is first sampled.
- R3: While `cnt_down_i` is low, carrier transitions leave the count unchanged.
- R4: A high `clear_i` sampled at a clock edge sets the count to 0 at that edge. It takes priority over counting.
- R5: Bit k of `sel_n_o` is low exactly when the count equals k and both bits of `dec_en_n_i` are 0. When either enable bit is 1, all sixteen bits are high.
- R6: With TERM_CH below 16, selecting channel TERM_CH clears the count on the next clock edge. That channel is therefore low for exactly one system clock, and the sequence repeats 0 to TERM_CH-1. With TERM_CH = 16 the count wraps from 15 to 0.
- R7: `carry_o` is high while the count is 15 and the registered carrier is high, which is the low phase of the count clock.
- R8: For each used channel k, `sw_en_o[2k]` and `sw_en_o[2k+1]` are both high exactly while channel k is selected.
- R9: `drive_o[k]` is high exactly when the carrier and burst gate, each registered one clock, are both high and channel k is selected.
- R10: `ind_o[k]` is the inverse of `sel_n_o[k]` for each used channel k < min(TERM_CH,16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_i | input | 1 | 50% duty carrier; its falling edge advances the count |
| burst_i | input | 1 | Burst-gate window |
| cnt_down_i | input | 1 | Must be high for counting to proceed |
| clear_i | input | 1 | Active-high count clear |
| dec_en_n_i | input | 2 | Active-low decoder enables; both must be 0 |
| sel_n_o | output | 16 | Active-low decoded channel selects |
| ind_o | output | NU | Active-high indicators for the used channels |
| sw_en_o | output | 2*NU | Switch-enable pairs, two per used channel |
| drive_o | output | NU | Carrier AND burst AND channel select |
| carry_o | output | 1 | Count-15 carry during the low phase of the count clock |

## Verification
Single carrier pulses with the count-enable high are used first to walk the sequence. This separates a clean advance from a missed or doubled step, and it confirms that the terminal channel is visible for one clock only. The same pulses are then repeated with the count-enable low, with the clear raised, and with each decoder enable raised in turn. These cases separate counting from holding, show that clear beats a step, and show that a disabled decoder forces every select line high. A second instance with no terminal feedback is taken through fifteen steps to expose the carry window and the natural wrap. A stimulus table that mixes carrier, burst and enable patterns is then compared against a cycle model of the requirements, so that the gated drive can be checked against the switch enables.

// File: rtl/seqsel_pkg.sv
package seqsel_pkg;
    localparam int CNT_W = 4;
    localparam int NCH   = 1 << CNT_W;

    typedef logic [CNT_W-1:0] cnt_t;

    // registered front-end samples
    typedef struct packed {
        logic car;    // carrier, one clock late
        logic car_d;  // carrier, two clocks late
        logic gate;   // burst window, one clock late
    } front_t;

    function automatic int used_ch(input int term);
        return (term >= NCH) ? NCH : term;
    endfunction
endpackage

// File: rtl/seqsel_counter.sv
module seqsel_counter
    import seqsel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic term_clr,
    input  logic step,
    input  logic down_hi,
    output cnt_t count
);
    always_ff @(posedge clk) begin
        if (rst)                 count <= '0;
        else if (clr || term_clr) count <= '0;
        else if (step && down_hi) count <= count + 1'b1;
    end
endmodule

// File: rtl/seqsel_decoder.sv
module seqsel_decoder
    import seqsel_pkg::*;
(
    input  cnt_t            count,
    input  logic [1:0]      en_n,
    output logic [NCH-1:0]  sel_n
);
    logic enabled;
    assign enabled = (en_n == 2'b00);

    for (genvar i = 0; i < NCH; i++) begin : g_line
        assign sel_n[i] = !(enabled && (count == cnt_t'(i)));
    end
endmodule

// File: rtl/seqsel_gate.sv
module seqsel_gate
    import seqsel_pkg::*;
#(
    parameter int NU = 3
) (
    input  logic [NU-1:0]   sel_n,
    input  front_t          fr,
    output logic [NU-1:0]   ind,
    output logic [2*NU-1:0] sw_en,
    output logic [NU-1:0]   drive
);
    for (genvar k = 0; k < NU; k++) begin : g_ch
        logic act;
        assign act          = !sel_n[k];
        assign ind[k]       = act;
        assign sw_en[2*k]   = act;
        assign sw_en[2*k+1] = act;
        assign drive[k]     = fr.car && fr.gate && act;
    end
endmodule

// File: rtl/seqsel_top.sv
module seqsel_top
    import seqsel_pkg::*;
#(
    parameter  int TERM_CH = 3,
    localparam int NU      = used_ch(TERM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            carrier_i,
    input  logic            burst_i,
    input  logic            cnt_down_i,
    input  logic            clear_i,
    input  logic [1:0]      dec_en_n_i,
    output logic [NCH-1:0]  sel_n_o,
    output logic [NU-1:0]   ind_o,
    output logic [2*NU-1:0] sw_en_o,
    output logic [NU-1:0]   drive_o,
    output logic            carry_o
);
    front_t fr;
    cnt_t   count_q;
    logic   step;
    logic   term_hit;

    always_ff @(posedge clk) begin
        if (rst) fr <= '0;
        else begin
            fr.car   <= carrier_i;
            fr.car_d <= fr.car;
            fr.gate  <= burst_i;
        end
    end

    // count clock is the inverted carrier: it rises when the carrier falls
    assign step = fr.car_d && !fr.car;

    if (TERM_CH < NCH) begin : g_fb
        assign term_hit = !sel_n_o[TERM_CH];
    end else begin : g_nofb
        assign term_hit = 1'b0;
    end

    seqsel_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clear_i),
        .term_clr (term_hit),
        .step     (step),
        .down_hi  (cnt_down_i),
        .count    (count_q)
    );

    seqsel_decoder u_dec (
        .count (count_q),
        .en_n  (dec_en_n_i),
        .sel_n (sel_n_o)
    );

    seqsel_gate #(.NU(NU)) u_gate (
        .sel_n (sel_n_o[NU-1:0]),
        .fr    (fr),
        .ind   (ind_o),
        .sw_en (sw_en_o),
        .drive (drive_o)
    );

    assign carry_o = (count_q == cnt_t'(NCH-1)) && fr.car;
endmodule

// File: rtl/seqsel_chk.sv
module seqsel_chk
    import seqsel_pkg::*;
#(
    parameter int TERM_CH = 3,
    parameter int NU      = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            clear_i,
    input logic            cnt_down_i,
    input logic [1:0]      dec_en_n_i,
    input logic [NCH-1:0]  sel_n_o,
    input logic [NU-1:0]   ind_o,
    input logic [2*NU-1:0] sw_en_o,
    input cnt_t            count_q,
    input logic            step
);
    logic term_seen;
    if (TERM_CH < NCH) begin : g_t
        assign term_seen = !sel_n_o[TERM_CH];

        // R6: terminal channel lasts one clock
        a_r6_term_one: assert property (@(posedge clk) disable iff (rst)
            term_seen && !clear_i |=> sel_n_o[TERM_CH]);
    end else begin : g_nt
        assign term_seen = 1'b0;
    end

    // R2: advance by one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        step && cnt_down_i && !clear_i && !term_seen
        |=> count_q == cnt_t'($past(count_q) + 1'b1));

    // R3: hold without a permitted step
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !(step && cnt_down_i) && !clear_i && !term_seen |=> $stable(count_q));

    // R4: clear wins
    a_r4_clear: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> count_q == '0);

    // R5: one low line when enabled, none otherwise
    a_r5_onecold: assert property (@(posedge clk) disable iff (rst)
        $countones(~sel_n_o) == ((dec_en_n_i == 2'b00) ? 1 : 0));

    // R8: each pair agrees with its indicator
    for (genvar k = 0; k < NU; k++) begin : g_pair
        a_r8_pair: assert property (@(posedge clk) disable iff (rst)
            sw_en_o[2*k] == ind_o[k] && sw_en_o[2*k+1] == ind_o[k]);
    end
endmodule

bind seqsel_top seqsel_chk #(.TERM_CH(TERM_CH), .NU(NU)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (clear_i),
    .cnt_down_i (cnt_down_i),
    .dec_en_n_i (dec_en_n_i),
    .sel_n_o    (sel_n_o),
    .ind_o      (ind_o),
    .sw_en_o    (sw_en_o),
    .count_q    (count_q),
    .step       (step)
);

// File: tb/tb_seqsel_top.sv
module tb_seqsel_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car = 1'b0, gate = 1'b0, down = 1'b1, clr = 1'b0;
    logic [1:0] en_n = 2'b00;

    logic [15:0] sel_n, sel16;
    logic [2:0]  ind, drv;
    logic [5:0]  sw;
    logic [15:0] ind16, drv16;
    logic [31:0] sw16;
    logic carry, carry16;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    seqsel_top #(.TERM_CH(3)) dut (
        .clk(clk), .rst(rst), .carrier_i(car), .burst_i(gate),
        .cnt_down_i(down), .clear_i(clr), .dec_en_n_i(en_n),
        .sel_n_o(sel_n), .ind_o(ind), .sw_en_o(sw), .drive_o(drv),
        .carry_o(carry));

    seqsel_top #(.TERM_CH(16)) dut16 (
        .clk(clk), .rst(rst), .carrier_i(car), .burst_i(gate),
        .cnt_down_i(down), .clear_i(clr), .dec_en_n_i(en_n),
        .sel_n_o(sel16), .ind_o(ind16), .sw_en_o(sw16), .drive_o(drv16),
        .carry_o(carry16));

    // cycle model written from the requirements
    logic m_car, m_card, m_gate;
    logic [3:0] m_c3, m_c16;
    always @(posedge clk) begin
        if (rst) begin
            m_car <= 0; m_card <= 0; m_gate <= 0; m_c3 <= 0; m_c16 <= 0;
        end else begin
            m_car <= car; m_card <= m_car; m_gate <= gate;
            if (clr) m_c3 <= 0;
            else if (en_n == 2'b00 && m_c3 == 4'd3) m_c3 <= 0;
            else if (m_card && !m_car && down) m_c3 <= m_c3 + 1'b1;
            if (clr) m_c16 <= 0;
            else if (m_card && !m_car && down) m_c16 <= m_c16 + 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        car = 1'b1; cyc(2);
        car = 1'b0; cyc(2);
    endtask

    function automatic logic [15:0] exp_sel(input logic [3:0] c);
        return (en_n == 2'b00) ? ~(16'd1 << c) : 16'hFFFF;
    endfunction

    task automatic model_cmp();
        logic [15:0] es;
        logic [2:0]  ei;
        es = exp_sel(m_c3);
        ei = ~es[2:0];
        chk("R5 sel", {16'd0, sel_n}, {16'd0, es});
        chk("R10 ind", {29'd0, ind}, {29'd0, ei});
        chk("R8 sw", {26'd0, sw}, {26'd0, {ei[2], ei[2], ei[1], ei[1], ei[0], ei[0]}});
        chk("R9 drive", {29'd0, drv}, {29'd0, ei & {3{m_car & m_gate}}});
        chk("R6 sel16", {16'd0, sel16}, {16'd0, exp_sel(m_c16)});
        chk("R7 carry16", {31'd0, carry16}, {31'd0, m_c16 == 4'd15 && m_car});
    endtask

    // {carrier, gate, down, clear, en_n[1:0]}, each held two clocks
    localparam logic [5:0] VEC [0:23] = '{
        6'b111000, 6'b011000, 6'b111000, 6'b011000, 6'b101000, 6'b001000,
        6'b111000, 6'b011001, 6'b111010, 6'b011000, 6'b110000, 6'b010000,
        6'b111000, 6'b011100, 6'b111000, 6'b011000, 6'b111011, 6'b011000,
        6'b101000, 6'b001000, 6'b111000, 6'b011000, 6'b111000, 6'b011000
    };

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 sel", {16'd0, sel_n}, 32'h0000FFFE);
        chk("R1 ind", {29'd0, ind}, 32'd1);
        chk("R1 drive", {29'd0, drv}, 32'd0);

        // R2 / R6 sequence 0,1,2 then terminal for one clock
        pulse();
        chk("R2 step1", {29'd0, ind}, 32'd2);
        pulse();
        chk("R2 step2", {29'd0, ind}, 32'd4);
        pulse();
        chk("R6 terminal low", {31'd0, sel_n[3]}, 32'd0);
        chk("R6 no used ind", {29'd0, ind}, 32'd0);
        cyc(1);
        chk("R6 back to 0", {16'd0, sel_n}, 32'h0000FFFE);

        // R3 hold while count-down line low
        down = 1'b0; pulse();
        chk("R3 hold", {29'd0, ind}, 32'd1);
        down = 1'b1;

        // R9 drive follows carrier and gate
        gate = 1'b1; car = 1'b1; cyc(2);
        chk("R9 drive on", {29'd0, drv}, 32'd1);
        chk("R8 pair", {26'd0, sw}, 32'h3);
        gate = 1'b0; cyc(2);
        chk("R9 gate off", {29'd0, drv}, 32'd0);
        car = 1'b0; cyc(2);
        chk("R2 step", {29'd0, ind}, 32'd2);

        // R4 clear
        clr = 1'b1; cyc(1); clr = 1'b0;
        chk("R4 clear", {29'd0, ind}, 32'd1);
        chk("R4 clear16", {16'd0, sel16}, 32'h0000FFFE);

        // R5 decoder enables
        en_n = 2'b01; cyc(1);
        chk("R5 en0 high", {16'd0, sel_n}, 32'h0000FFFF);
        en_n = 2'b10; cyc(1);
        chk("R5 en1 high", {16'd0, sel_n}, 32'h0000FFFF);
        chk("R10 ind off", {29'd0, ind}, 32'd0);
        en_n = 2'b00; cyc(1);

        // R7 carry and natural wrap on the unfed instance
        for (int i = 0; i < 15; i++) pulse();
        chk("R6 at 15", {16'd0, sel16}, 32'h00007FFF);
        chk("R7 carry low phase", {31'd0, carry16}, 32'd0);
        car = 1'b1; cyc(1);
        chk("R7 carry high", {31'd0, carry16}, 32'd1);
        car = 1'b0; cyc(2);
        chk("R6 wrap", {16'd0, sel16}, 32'h0000FFFE);
        chk("R7 carry drop", {31'd0, carry16}, 32'd0);

        // table walk against the model
        for (int v = 0; v < 24; v++) begin
            {car, gate, down, clr, en_n} = VEC[v];
            for (int h = 0; h < 2; h++) begin
                cyc(1);
                model_cmp();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule